// File: doc/BRIEF.md
# D-PHY Power-Up Sequencer

This block brings a D-PHY transmitter interface out of reset and reports when it is usable. A small register interface carries two words. The control word drives four PHY control lines: shutdown-not, reset-not, clock enable and force-PLL. The interface word holds the lane count and the stop-wait time that the PHY needs. Writing the all-ones enable pattern to the control word starts a fixed bring-up. The PHY is first held fully off. A test-clear pulse is then issued, and the four control lines are released together.

After the release the sequencer waits for two status inputs from the analog side. The first is PLL lock, and only after it comes the clock-lane stop state. Each wait is bounded by its own timeout, built from a cycles-per-millisecond parameter. A wait that expires raises a sticky flag for that stage, and the sequence carries on to the next stage. The ready output rises only when both status events were seen in time. Clearing the shutdown-not bit of the control word at any point returns the block to the off state.

Top module: `dphy_pwr_seq`

## Requirements
- R1: After reset the four PHY control outputs, test-clear, ready and both timeout flags are low, the lane field reads 0 and the stop-wait field reads 0.
- R2: A control write of 4'hF (bit 0 shutdown-not, bit 1 reset-not, bit 2 clock enable, bit 3 force-PLL) while off holds all control outputs low. Test-clear then stays low for one cycle, goes high for TCLR_CYCLES cycles and goes low for one further cycle.
- R3: In the cycle after the final low test-clear cycle, all four control outputs rise together in the same cycle.
- R4: During the lock wait, if no synchronized lock is seen, lock_timeout rises exactly TIMEOUT_MS*CYC_PER_MS cycles after the control outputs rise, and the sequence moves on to the stop-state wait.
- R5: The stop-state wait starts when lock is seen or times out. If no synchronized stop state is seen, stop_timeout rises exactly TIMEOUT_MS*CYC_PER_MS cycles after the wait begins, and the sequence then ends.
- R6: seq_ready is high only after both waits have ended with neither timeout flag set. Once the sequence has ended, the control outputs stay high whether or not ready is set.
- R7: A control write with bit 0 clear, in any state, drives all control outputs, test-clear and ready low from the next cycle.
- R8: A control write of any value other than 4'hF while off starts nothing. A control write with bit 0 set while a sequence runs or has ended changes nothing.
- R9: Timeout flags stay set through an abort and are cleared when the next sequence starts.
- R10: An interface-word write (reg_sel=1) loads the stop-wait time from bits 15:8 and the lane count minus one from bits 1:0. A lane value of MAX_LANES or more leaves the lane field unchanged, while the stop-wait part is still applied.
- R11: stat_word reports synchronized lock in bit 0 and synchronized clock-lane stop state in bit 2. Bits 1 and 3 read 0.
- R12: Lock and stop-state inputs pass through SYNC_STAGES flip-flops, so a change shows in stat_word SYNC_STAGES cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 the interface word |
| reg_wdata | input | 16 | Write data |
| phy_lock_i | input | 1 | PLL lock from PHY (asynchronous) |
| phy_stopclk_i | input | 1 | Clock-lane stop state from PHY (asynchronous) |
| phy_shutdown_n | output | 1 | PHY shutdown-not |
| phy_reset_n | output | 1 | PHY reset-not |
| phy_clk_en | output | 1 | PHY clock enable |
| phy_force_pll | output | 1 | PHY force-PLL |
| phy_test_clr | output | 1 | PHY test-clear |
| if_lanes_m1 | output | 2 | Lane count minus one |
| if_stop_wait | output | 8 | Stop-wait time |
| stat_word | output | 4 | Status: bit 0 lock, bit 2 stop state |
| lock_timeout | output | 1 | Sticky lock-wait timeout |
| stop_timeout | output | 1 | Sticky stop-wait timeout |
| seq_ready | output | 1 | Bring-up complete without timeout |

## Verification
The assertions assume two things about the inputs. First, reg_wdata holds a known value whenever reg_we is high. Second, lock and stop-state are level signals that count only after the synchronizer, so nothing is claimed about the raw pins. The stimulus drives every input just after a falling edge. In the random trials, each status input either never arrives or arrives well inside the timeout window, several cycles away from the expiry cycle, so the expected flags do not depend on the exact synchronizer latency. The exact expiry cycle is checked only in directed runs, where the status input is held constant.

// File: rtl/dphy_pwr_pkg.sv
package dphy_pwr_pkg;

   typedef enum logic [2:0] {
      SEQ_OFF       = 3'd0,
      SEQ_CLEAR     = 3'd1,
      SEQ_TCLR_HI   = 3'd2,
      SEQ_TCLR_LO   = 3'd3,
      SEQ_WAIT_LOCK = 3'd4,
      SEQ_WAIT_STOP = 3'd5,
      SEQ_DONE      = 3'd6
   } seq_state_e;

   typedef struct packed {
      logic force_pll;
      logic clk_en;
      logic reset_n;
      logic shutdown_n;
   } phy_ctrl_t;

   localparam logic SEL_CTRL  = 1'b0;
   localparam logic SEL_IFCFG = 1'b1;

   localparam logic [3:0] CTRL_ALL_ON = 4'hF;

endpackage

// File: rtl/dphy_pwr_sync.sv
module dphy_pwr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES > 8) begin : g_bad_stages
      $error("dphy_pwr_sync: STAGES must be 0 to 8");
   end

   if (STAGES == 0) begin : g_bypass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '0;
         end else begin
            sr[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
               sr[i] <= sr[i-1];
            end
         end
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/dphy_pwr_timer.sv
module dphy_pwr_timer #(
   parameter int unsigned LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic dec,
   output logic zero
);

   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] CNT_TOP = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("dphy_pwr_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CNT_TOP;
      end else if (load) begin
         cnt <= CNT_TOP;
      end else if (dec && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

   AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_TOP); // R4

   AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == CNT_TOP)); // R5

endmodule

// File: rtl/dphy_pwr_cfg.sv
module dphy_pwr_cfg #(
   parameter int unsigned LANE_W    = 2,
   parameter int unsigned STOP_W    = 8,
   parameter int unsigned MAX_LANES = 4,
   localparam int unsigned DATA_W   = 8 + STOP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANE_W-1:0] lanes_m1,
   output logic [STOP_W-1:0] stop_wait
);

   localparam logic [LANE_W:0] LANE_LIMIT = (LANE_W + 1)'(MAX_LANES);

   if (LANE_W < 1 || LANE_W > 8) begin : g_bad_lane_w
      $error("dphy_pwr_cfg: LANE_W must be 1 to 8");
   end
   if (MAX_LANES < 1 || MAX_LANES > (1 << LANE_W)) begin : g_bad_lanes
      $error("dphy_pwr_cfg: MAX_LANES out of range for LANE_W");
   end

   logic [LANE_W-1:0] lane_req;
   logic              lane_ok;
   logic [DATA_W-1:0] unused_bits;

   assign lane_req    = wdata[LANE_W-1:0];
   assign lane_ok     = ({1'b0, lane_req} < LANE_LIMIT);
   assign unused_bits = wdata & {{STOP_W{1'b0}}, {(8 - LANE_W){1'b1}}, {LANE_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lanes_m1  <= '0;
         stop_wait <= '0;
      end else if (wr_en) begin
         stop_wait <= wdata[8 +: STOP_W];
         if (lane_ok) begin
            lanes_m1 <= lane_req;
         end
      end
   end

   AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, lanes_m1} < LANE_LIMIT); // R10

   AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !lane_ok) |=> $stable(lanes_m1)); // R10

endmodule

// File: rtl/dphy_pwr_fsm.sv
module dphy_pwr_fsm
   import dphy_pwr_pkg::*;
#(
   parameter int unsigned TCLR_CYCLES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      abort,
   input  logic      lock_s,
   input  logic      stop_s,
   input  logic      tmr_zero,
   output logic      tmr_load,
   output logic      tmr_dec,
   output phy_ctrl_t ctrl,
   output logic      test_clr,
   output logic      lock_to,
   output logic      stop_to,
   output logic      ready
);

   localparam int unsigned PW = (TCLR_CYCLES > 1) ? $clog2(TCLR_CYCLES) : 1;
   localparam logic [PW-1:0] PULSE_TOP = PW'(TCLR_CYCLES - 1);

   if (TCLR_CYCLES < 1) begin : g_bad_tclr
      $error("dphy_pwr_fsm: TCLR_CYCLES must be at least 1");
   end

   seq_state_e st, nxt;
   logic [PW-1:0] pcnt;
   logic released;

   always_comb begin
      nxt = st;
      unique case (st)
         SEQ_OFF:       if (start) nxt = SEQ_CLEAR;
         SEQ_CLEAR:     nxt = SEQ_TCLR_HI;
         SEQ_TCLR_HI:   if (pcnt == '0) nxt = SEQ_TCLR_LO;
         SEQ_TCLR_LO:   nxt = SEQ_WAIT_LOCK;
         SEQ_WAIT_LOCK: if (lock_s || tmr_zero) nxt = SEQ_WAIT_STOP;
         SEQ_WAIT_STOP: if (stop_s || tmr_zero) nxt = SEQ_DONE;
         SEQ_DONE:      nxt = SEQ_DONE;
         default:       nxt = SEQ_OFF;
      endcase
      if (abort) nxt = SEQ_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SEQ_OFF;
      end else begin
         st <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= PULSE_TOP;
      end else if (st != SEQ_TCLR_HI) begin
         pcnt <= PULSE_TOP;
      end else if (pcnt != '0) begin
         pcnt <= pcnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_to <= 1'b0;
         stop_to <= 1'b0;
      end else if ((st == SEQ_OFF) && start && !abort) begin
         lock_to <= 1'b0;
         stop_to <= 1'b0;
      end else begin
         if ((st == SEQ_WAIT_LOCK) && !lock_s && tmr_zero && !abort) lock_to <= 1'b1;
         if ((st == SEQ_WAIT_STOP) && !stop_s && tmr_zero && !abort) stop_to <= 1'b1;
      end
   end

   assign tmr_load = (nxt != st);
   assign tmr_dec  = !tmr_load && ((st == SEQ_WAIT_LOCK) || (st == SEQ_WAIT_STOP));
   assign released = (st == SEQ_WAIT_LOCK) || (st == SEQ_WAIT_STOP) || (st == SEQ_DONE);

   assign ctrl.shutdown_n = released;
   assign ctrl.reset_n    = released;
   assign ctrl.clk_en     = released;
   assign ctrl.force_pll  = released;
   assign test_clr        = (st == SEQ_TCLR_HI);
   assign ready           = (st == SEQ_DONE) && !lock_to && !stop_to;

   AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_to && !start) |=> lock_to); // R9

   AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_to && !start) |=> stop_to); // R9

   AST_TCLR_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      test_clr |-> !ctrl.shutdown_n); // R2

   AST_READY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ctrl.shutdown_n && !test_clr)); // R6

endmodule

// File: rtl/dphy_pwr_seq.sv
module dphy_pwr_seq
   import dphy_pwr_pkg::*;
#(
   parameter int unsigned CYC_PER_MS  = 1000,
   parameter int unsigned TIMEOUT_MS  = 10,
   parameter int unsigned TCLR_CYCLES = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MAX_LANES   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic        reg_sel,
   input  logic [15:0] reg_wdata,
   input  logic        phy_lock_i,
   input  logic        phy_stopclk_i,
   output logic        phy_shutdown_n,
   output logic        phy_reset_n,
   output logic        phy_clk_en,
   output logic        phy_force_pll,
   output logic        phy_test_clr,
   output logic [1:0]  if_lanes_m1,
   output logic [7:0]  if_stop_wait,
   output logic [3:0]  stat_word,
   output logic        lock_timeout,
   output logic        stop_timeout,
   output logic        seq_ready
);

   localparam int unsigned LANE_W = 2;
   localparam int unsigned STOP_W = 8;
   localparam int unsigned LIMIT  = CYC_PER_MS * TIMEOUT_MS;

   if (CYC_PER_MS < 1 || TIMEOUT_MS < 1) begin : g_bad_timeout
      $error("dphy_pwr_seq: timeout parameters must be at least 1");
   end

   logic      lock_s, stop_s;
   logic      ctrl_wr, cfg_wr, start, abort;
   logic      tmr_load, tmr_dec, tmr_zero;
   phy_ctrl_t ctrl;

   assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
   assign cfg_wr  = reg_we && (reg_sel == SEL_IFCFG);
   assign start   = ctrl_wr && (reg_wdata[3:0] == CTRL_ALL_ON);
   assign abort   = ctrl_wr && !reg_wdata[0];

   dphy_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
      .clk(clk), .rst_n(rst_n), .d(phy_lock_i), .q(lock_s)
   );

   dphy_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
      .clk(clk), .rst_n(rst_n), .d(phy_stopclk_i), .q(stop_s)
   );

   dphy_pwr_timer #(.LIMIT(LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .dec(tmr_dec), .zero(tmr_zero)
   );

   dphy_pwr_cfg #(
      .LANE_W(LANE_W), .STOP_W(STOP_W), .MAX_LANES(MAX_LANES)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(reg_wdata),
      .lanes_m1(if_lanes_m1), .stop_wait(if_stop_wait)
   );

   dphy_pwr_fsm #(.TCLR_CYCLES(TCLR_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .lock_s(lock_s), .stop_s(stop_s), .tmr_zero(tmr_zero),
      .tmr_load(tmr_load), .tmr_dec(tmr_dec), .ctrl(ctrl),
      .test_clr(phy_test_clr), .lock_to(lock_timeout),
      .stop_to(stop_timeout), .ready(seq_ready)
   );

   assign phy_shutdown_n = ctrl.shutdown_n;
   assign phy_reset_n    = ctrl.reset_n;
   assign phy_clk_en     = ctrl.clk_en;
   assign phy_force_pll  = ctrl.force_pll;
   assign stat_word      = {1'b0, stop_s, 1'b0, lock_s};

   AST_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!phy_shutdown_n && !phy_test_clr && !seq_ready)); // R7

   AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_shutdown_n) |-> (phy_reset_n && phy_clk_en && phy_force_pll)); // R3

   AST_RELEASE_AFTER_TCLR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_shutdown_n) |-> !phy_test_clr); // R2

endmodule

// File: tb/dphy_pwr_seq_test.sv
module dphy_pwr_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int CPM  = 8;
   localparam int TMS  = 3;
   localparam int LIM  = CPM * TMS;
   localparam int TCLR = 3;
   localparam int SYNC = 2;
   localparam int MAXL = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        lock_i = 1'b0;
   logic        stop_i = 1'b0;
   logic        shdn_n, rst_n_o, clk_en, fpll, tclr;
   logic [1:0]  lanes;
   logic [7:0]  swait;
   logic [3:0]  stat;
   logic        lock_to, stop_to, ready;

   int checks = 0;
   int failures = 0;
   logic [1:0] m_lanes = '0;
   logic [7:0] m_swait = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dphy_pwr_seq #(
      .CYC_PER_MS(CPM), .TIMEOUT_MS(TMS), .TCLR_CYCLES(TCLR),
      .SYNC_STAGES(SYNC), .MAX_LANES(MAXL)
   ) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .phy_lock_i(lock_i), .phy_stopclk_i(stop_i),
      .phy_shutdown_n(shdn_n), .phy_reset_n(rst_n_o), .phy_clk_en(clk_en),
      .phy_force_pll(fpll), .phy_test_clr(tclr), .if_lanes_m1(lanes),
      .if_stop_wait(swait), .stat_word(stat), .lock_timeout(lock_to),
      .stop_timeout(stop_to), .seq_ready(ready)
   );

   function automatic logic [3:0] ctrl_bits();
      return {fpll, clk_en, rst_n_o, shdn_n};
   endfunction

   function automatic logic lane_accept(input logic [1:0] v);
      return int'(v) < MAXL;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic sel, input logic [15:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic to_release();
      for (int i = 0; i < 20; i++) begin
         if (shdn_n) break;
         step(1);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0417));
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1", "ctrl", 32'(ctrl_bits()), 0);
      chk("R1", "tclr", 32'(tclr), 0);
      chk("R1", "flags", 32'({ready, lock_to, stop_to}), 0);
      chk("R1", "cfg", 32'({lanes, swait}), 0);

      // R11 R12 synchronizer latency and bit positions
      lock_i = 1'b1;
      step(1);
      chk("R12", "lock after 1", 32'(stat[0]), 0);
      step(1);
      chk("R12", "lock after 2", 32'(stat[0]), 1);
      stop_i = 1'b1;
      step(1);
      chk("R12", "stop after 1", 32'(stat[2]), 0);
      step(1);
      chk("R11", "stat word", 32'(stat), 32'h5);

      // R8 non-enable pattern while off
      reg_wr(1'b0, 16'h0007);
      step(3);
      chk("R8", "ctrl after 7", 32'(ctrl_bits()), 0);
      chk("R8", "tclr after 7", 32'(tclr), 0);

      // R2 R3 nominal bring-up, lock and stop already present
      reg_wr(1'b0, 16'h000F);
      chk("R2", "clear tclr", 32'(tclr), 0);
      chk("R2", "clear ctrl", 32'(ctrl_bits()), 0);
      for (int i = 0; i < TCLR; i++) begin
         step(1);
         chk("R2", "pulse tclr", 32'(tclr), 1);
         chk("R2", "pulse ctrl", 32'(ctrl_bits()), 0);
      end
      step(1);
      chk("R2", "tail tclr", 32'(tclr), 0);
      chk("R2", "tail ctrl", 32'(ctrl_bits()), 0);
      step(1);
      chk("R3", "release", 32'(ctrl_bits()), 32'hF);
      step(1);
      chk("R6", "ready early", 32'(ready), 0);
      step(1);
      chk("R6", "ready", 32'(ready), 1);
      chk("R6", "no flags", 32'({lock_to, stop_to}), 0);

      // R8 writes with bit 0 set while done
      reg_wr(1'b0, 16'h000F);
      reg_wr(1'b0, 16'h000B);
      step(1);
      chk("R8", "ready kept", 32'(ready), 1);
      chk("R8", "ctrl kept", 32'(ctrl_bits()), 32'hF);

      // R7 abort
      reg_wr(1'b0, 16'h0000);
      chk("R7", "abort ctrl", 32'(ctrl_bits()), 0);
      chk("R7", "abort ready", 32'(ready), 0);

      // R7 abort during test-clear pulse
      reg_wr(1'b0, 16'h000F);
      step(1);
      reg_wr(1'b0, 16'h000E);
      chk("R7", "abort in pulse", 32'({tclr, ctrl_bits()}), 0);
      step(2);

      // R4 lock timeout, exact cycle
      lock_i = 1'b0;
      step(3);
      reg_wr(1'b0, 16'h000F);
      to_release();
      chk("R3", "released", 32'(ctrl_bits()), 32'hF);
      step(LIM - 1);
      chk("R4", "before expiry", 32'(lock_to), 0);
      step(1);
      chk("R4", "at expiry", 32'(lock_to), 1);
      step(1);
      chk("R6", "ready with lock timeout", 32'(ready), 0);
      chk("R5", "stop flag", 32'(stop_to), 0);
      chk("R6", "ctrl held", 32'(ctrl_bits()), 32'hF);

      // R9 sticky across abort, cleared on start
      reg_wr(1'b0, 16'h0000);
      chk("R9", "sticky after abort", 32'(lock_to), 1);
      lock_i = 1'b1; stop_i = 1'b0;
      step(3);
      reg_wr(1'b0, 16'h000F);
      chk("R9", "cleared at start", 32'(lock_to), 0);

      // R5 stop timeout, exact cycle
      to_release();
      step(1 + LIM - 1);
      chk("R5", "before expiry", 32'(stop_to), 0);
      step(1);
      chk("R5", "at expiry", 32'(stop_to), 1);
      chk("R4", "no lock flag", 32'(lock_to), 0);
      step(1);
      chk("R6", "ready with stop timeout", 32'(ready), 0);

      // R4 R5 R6 random arrival trials
      for (int t = 0; t < 24; t++) begin
         bit nl, ns;
         int dl, ds;
         reg_wr(1'b0, 16'h0000);
         lock_i = 1'b0; stop_i = 1'b0;
         nl = ($urandom % 3) == 0;
         ns = ($urandom % 3) == 0;
         dl = $urandom % (LIM - 8);
         ds = $urandom % (LIM - 8);
         step(3);
         reg_wr(1'b0, 16'h000F);
         to_release();
         for (int k = 0; k < 2 * LIM + 8; k++) begin
            if (!nl && k == dl) lock_i = 1'b1;
            if (!ns && k == ds) stop_i = 1'b1;
            step(1);
         end
         chk("R4", "random lock flag", 32'(lock_to), 32'(nl));
         chk("R5", "random stop flag", 32'(stop_to), 32'(ns));
         chk("R6", "random ready", 32'(ready), 32'(!nl && !ns));
      end

      // R10 configuration, directed then random
      reg_wr(1'b1, 16'h5A01);
      m_lanes = 2'd1; m_swait = 8'h5A;
      chk("R10", "lanes accepted", 32'(lanes), 32'(m_lanes));
      reg_wr(1'b1, 16'h3303);
      m_swait = 8'h33;
      chk("R10", "lanes rejected", 32'(lanes), 32'(m_lanes));
      chk("R10", "stop wait kept", 32'(swait), 32'(m_swait));
      for (int t = 0; t < 30; t++) begin
         logic [15:0] d;
         d = 16'($urandom);
         reg_wr(1'b1, d);
         m_swait = d[15:8];
         if (lane_accept(d[1:0])) m_lanes = d[1:0];
         chk("R10", "random cfg", 32'({lanes, swait}), 32'({m_lanes, m_swait}));
      end

      finish_run();
   end

endmodule